// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address stream for a single bank of a synchronous DRAM. Software or a controller first loads a mode word. The mode word sets the burst length, the order of addresses inside a burst, and whether write bursts are cut to one beat. Each read or write command then supplies a starting column. From the next clock on, the block emits one column address per cycle, marked by a valid flag, until the burst is complete.

A running burst can be cut short in two ways. A fresh read or write starts a new burst at its own column, and these may arrive on every clock. A precharge of the bank stops the burst. Neither interruption is allowed while the running burst was issued with auto precharge. In that case the interrupting command is dropped, a reject pulse is raised, and the burst carries on. A mode load that arrives during a burst is also dropped, and an error pulse is raised.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The length code in mode bits [2:0] selects the beat count: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. Codes 100 to 110 give 1. The first address appears with col_vld_o high on the clock after the command, and one address follows on each clock after that.
- R2: With mode bit 3 low, the low log2(length) bits of the address count upward from the start column and wrap inside the aligned block. The upper bits keep the start value.
- R3: With mode bit 3 high, the low log2(length) bits equal the start bits XOR the beat index. For lengths 1 and 2 this gives the same order as R2.
- R4: Length code 111 selects full-page mode. The whole column field counts upward from the start and wraps at 2^COL_W. The burst never ends by itself and never raises burst_done_o.
- R5: A read or write command accepted during a burst without auto precharge ends that burst. Its own start column appears on the next clock. Commands may follow each other on every clock.
- R6: A precharge during a burst without auto precharge drops col_vld_o on the next clock, with no burst_done_o. A precharge while no burst runs has no effect.
- R7: While a burst issued with auto precharge runs, an incoming read, write or precharge is ignored. cmd_reject_o pulses on the next clock and the burst continues with its next address.
- R8: A mode load while a burst runs is ignored and mode_err_o pulses on the next clock. A mode load while idle takes effect for the next command.
- R9: With mode bit 9 high, write bursts have one beat and read bursts keep the programmed length.
- R10: burst_done_o is high, together with col_vld_o, on exactly the cycle that carries the last address of a burst that ran to completion.
- R11: After reset all outputs are low and the mode is length 1, sequential order, with full write bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_load_i | input | 1 | Load the mode word |
| mode_bits_i | input | MODE_W | Mode word: [2:0] length code, [3] order, [9] single-beat write |
| cmd_rw_i | input | 1 | Read or write command strobe |
| cmd_write_i | input | 1 | Command is a write |
| cmd_ap_i | input | 1 | Command carries auto precharge |
| cmd_col_i | input | COL_W | Start column of the command |
| pre_i | input | 1 | Precharge of this bank |
| col_o | output | COL_W | Current burst column address |
| col_vld_o | output | 1 | col_o carries a burst address |
| burst_done_o | output | 1 | Last address of a completed burst |
| cmd_reject_o | output | 1 | A command was refused because of auto precharge |
| mode_err_o | output | 1 | A mode load was refused during a burst |

## Verification
The bench targets the wrap point inside aligned blocks. A design that carried into the upper bits would leave the block at the seam, and a design that used addition instead of XOR in interleaved order would scramble the length 4 and 8 sequences. It checks that length 1 and 2 give the same order in both modes, and that full page crosses the top of the row back to zero. Several cases check interrupts: a burst restarted mid-way and on back-to-back clocks, and a precharge that must clear valid without a done pulse. Under auto precharge, both kinds of interrupt must be refused while the addresses keep stepping. The bench also checks that a mode load during a burst leaves the running length unchanged, and that a single-beat write does not shorten reads.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

   localparam logic [2:0] LEN_CODE_1    = 3'b000;
   localparam logic [2:0] LEN_CODE_2    = 3'b001;
   localparam logic [2:0] LEN_CODE_4    = 3'b010;
   localparam logic [2:0] LEN_CODE_8    = 3'b011;
   localparam logic [2:0] LEN_CODE_FULL = 3'b111;

   localparam int ORDER_BIT   = 3;
   localparam int WSINGLE_BIT = 9;

   typedef struct packed {
      logic       wr_single;
      logic       interleave;
      logic [2:0] len_code;
   } burst_mode_t;

   localparam burst_mode_t MODE_RESET = '{wr_single: 1'b0, interleave: 1'b0, len_code: LEN_CODE_1};

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
   import sdram_burst_pkg::*;
#(
   parameter int MODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [MODE_W-1:0] bits_i,
   input  logic              busy_i,
   output burst_mode_t       mode_o,
   output logic              err_o
);

   generate
      if (MODE_W <= WSINGLE_BIT) begin : g_bad_width
         $error("burst_mode_reg: MODE_W must exceed the single-write bit index");
      end
   endgenerate

   burst_mode_t mode_q;
   logic        err_q;
   logic        take;

   logic unused_bits;
   assign unused_bits = ^bits_i;

   assign take = load_i && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         err_q  <= 1'b0;
      end else begin
         err_q <= load_i && busy_i;
         if (take) begin
            mode_q.len_code   <= bits_i[2:0];
            mode_q.interleave <= bits_i[ORDER_BIT];
            mode_q.wr_single  <= bits_i[WSINGLE_BIT];
         end
      end
   end

   assign mode_o = mode_q;
   assign err_o  = err_q;

   AST_MODE_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && busy_i) |=> err_o);                                // R8
   AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && busy_i) |=> $stable(mode_q));                      // R8

endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
   parameter int COL_W  = 8,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] idx_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] addr_o
);

   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] ilv_low;
   logic [COL_W-1:0] high_part;

   assign high_part = base_i & ~mask_i;
   assign seq_low   = (base_i + idx_i) & mask_i;

   generate
      if (ILV_EN) begin : g_ilv
         assign ilv_low = (base_i ^ idx_i) & mask_i;
         assign addr_o  = high_part | (ilv_i ? ilv_low : seq_low);
      end else begin : g_seq_only
         logic unused_ilv;
         assign unused_ilv = ilv_i;
         assign ilv_low    = seq_low;
         assign addr_o     = high_part | seq_low;
      end
   endgenerate

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
   import sdram_burst_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter bit FP_EN  = 1'b1,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_rw_i,
   input  logic             cmd_write_i,
   input  logic             cmd_ap_i,
   input  logic [COL_W-1:0] cmd_col_i,
   input  logic             pre_i,
   input  burst_mode_t      mode_i,
   output logic             busy_o,
   output logic [COL_W-1:0] col_o,
   output logic             col_vld_o,
   output logic             done_o,
   output logic             reject_o
);

   localparam logic [COL_W-1:0] ZERO = '0;
   localparam logic [COL_W-1:0] ONES = '1;

   generate
      if (COL_W < 4 || COL_W > 16) begin : g_bad_col
         $error("burst_seq_ctrl: COL_W must lie in 4..16");
      end
   endgenerate

   logic             active_q, ap_q, fp_q, ilv_q;
   logic [COL_W-1:0] start_q, cnt_q, mask_q;
   logic [COL_W-1:0] col_q;
   logic             vld_q, done_q, rej_q;

   logic             mode_fp;
   logic [COL_W-1:0] mode_mask;
   logic             single_wr;
   logic             eff_fp, eff_ilv;
   logic [COL_W-1:0] eff_mask;
   logic             blocked, accept, pre_stop;
   logic [COL_W-1:0] calc_base, calc_idx, calc_mask, calc_addr;
   logic             calc_ilv;
   logic             first_last, beat_last;

   generate
      if (FP_EN) begin : g_fp
         assign mode_fp = (mode_i.len_code == LEN_CODE_FULL);
      end else begin : g_no_fp
         assign mode_fp = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (mode_i.len_code)
         LEN_CODE_2: mode_mask = COL_W'(1);
         LEN_CODE_4: mode_mask = COL_W'(3);
         LEN_CODE_8: mode_mask = COL_W'(7);
         default:    mode_mask = mode_fp ? ONES : ZERO;
      endcase
   end

   assign single_wr = cmd_write_i && mode_i.wr_single;
   assign eff_fp    = mode_fp && !single_wr;
   assign eff_mask  = single_wr ? ZERO : mode_mask;
   assign eff_ilv   = mode_i.interleave && !eff_fp;

   assign blocked  = active_q && ap_q;
   assign accept   = cmd_rw_i && !blocked;
   assign pre_stop = pre_i && active_q && !ap_q && !cmd_rw_i;

   assign calc_base = accept ? cmd_col_i : start_q;
   assign calc_idx  = accept ? ZERO      : cnt_q + COL_W'(1);
   assign calc_mask = accept ? eff_mask  : mask_q;
   assign calc_ilv  = accept ? eff_ilv   : ilv_q;

   burst_addr_calc #(
      .COL_W (COL_W),
      .ILV_EN(ILV_EN)
   ) addr_calc_i (
      .base_i(calc_base),
      .idx_i (calc_idx),
      .mask_i(calc_mask),
      .ilv_i (calc_ilv),
      .addr_o(calc_addr)
   );

   assign first_last = (eff_mask == ZERO) && !eff_fp;
   assign beat_last  = (calc_idx == mask_q) && !fp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ap_q     <= 1'b0;
         fp_q     <= 1'b0;
         ilv_q    <= 1'b0;
         start_q  <= '0;
         cnt_q    <= '0;
         mask_q   <= '0;
         col_q    <= '0;
         vld_q    <= 1'b0;
         done_q   <= 1'b0;
         rej_q    <= 1'b0;
      end else begin
         rej_q <= blocked && (cmd_rw_i || pre_i);
         if (accept) begin
            start_q  <= cmd_col_i;
            cnt_q    <= '0;
            mask_q   <= eff_mask;
            fp_q     <= eff_fp;
            ilv_q    <= eff_ilv;
            ap_q     <= cmd_ap_i;
            col_q    <= calc_addr;
            vld_q    <= 1'b1;
            done_q   <= first_last;
            active_q <= !first_last;
         end else if (pre_stop) begin
            active_q <= 1'b0;
            vld_q    <= 1'b0;
            done_q   <= 1'b0;
         end else if (active_q) begin
            cnt_q    <= calc_idx;
            col_q    <= calc_addr;
            vld_q    <= 1'b1;
            done_q   <= beat_last;
            active_q <= !beat_last;
         end else begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
         end
      end
   end

   assign busy_o    = active_q;
   assign col_o     = col_q;
   assign col_vld_o = vld_q;
   assign done_o    = done_q;
   assign reject_o  = rej_q;

   AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> col_vld_o);                                        // R10
   AST_CMD_STARTS_AT_COL: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (col_vld_o && col_o == $past(cmd_col_i)));         // R5
   AST_PRE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      pre_stop |=> (!col_vld_o && !done_o));                        // R6
   AST_AP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && (cmd_rw_i || pre_i)) |=> (reject_o && col_vld_o)); // R7
   AST_FULLPAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && fp_q && !cmd_rw_i && !pre_i)
         |=> (col_o == $past(col_o) + COL_W'(1) && !done_o));       // R4

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import sdram_burst_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter int MODE_W = 10,
   parameter bit FP_EN  = 1'b1,
   parameter bit ILV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_load_i,
   input  logic [MODE_W-1:0] mode_bits_i,
   input  logic              cmd_rw_i,
   input  logic              cmd_write_i,
   input  logic              cmd_ap_i,
   input  logic [COL_W-1:0]  cmd_col_i,
   input  logic              pre_i,
   output logic [COL_W-1:0]  col_o,
   output logic              col_vld_o,
   output logic              burst_done_o,
   output logic              cmd_reject_o,
   output logic              mode_err_o
);

   burst_mode_t mode;
   logic        busy;

   burst_mode_reg #(
      .MODE_W(MODE_W)
   ) mode_reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(mode_load_i),
      .bits_i(mode_bits_i),
      .busy_i(busy),
      .mode_o(mode),
      .err_o (mode_err_o)
   );

   burst_seq_ctrl #(
      .COL_W (COL_W),
      .FP_EN (FP_EN),
      .ILV_EN(ILV_EN)
   ) seq_ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_rw_i   (cmd_rw_i),
      .cmd_write_i(cmd_write_i),
      .cmd_ap_i   (cmd_ap_i),
      .cmd_col_i  (cmd_col_i),
      .pre_i      (pre_i),
      .mode_i     (mode),
      .busy_o     (busy),
      .col_o      (col_o),
      .col_vld_o  (col_vld_o),
      .done_o     (burst_done_o),
      .reject_o   (cmd_reject_o)
   );

endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb_top;

   localparam int COL_W  = 8;
   localparam int MODE_W = 10;
   localparam int NVEC   = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_load_i = 1'b0;
   logic [MODE_W-1:0] mode_bits_i = '0;
   logic              cmd_rw_i = 1'b0;
   logic              cmd_write_i = 1'b0;
   logic              cmd_ap_i = 1'b0;
   logic [COL_W-1:0]  cmd_col_i = '0;
   logic              pre_i = 1'b0;
   logic [COL_W-1:0]  col_o;
   logic              col_vld_o, burst_done_o, cmd_reject_o, mode_err_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   sdram_burst_colgen #(.COL_W(COL_W), .MODE_W(MODE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_load_i(mode_load_i), .mode_bits_i(mode_bits_i),
      .cmd_rw_i(cmd_rw_i), .cmd_write_i(cmd_write_i), .cmd_ap_i(cmd_ap_i),
      .cmd_col_i(cmd_col_i), .pre_i(pre_i), .col_o(col_o), .col_vld_o(col_vld_o),
      .burst_done_o(burst_done_o), .cmd_reject_o(cmd_reject_o), .mode_err_o(mode_err_o)
   );

   // vector: mode[86:77] col[76:69] write[68] len[67:64] beats[63:0] (beat 0 on top)
   localparam logic [86:0] VEC [NVEC] = '{
      {10'h003, 8'h2D, 1'b0, 4'd8, 64'h2D2E2F28292A2B2C},
      {10'h00B, 8'h2D, 1'b0, 4'd8, 64'h2D2C2F2E29282B2A},
      {10'h002, 8'h46, 1'b0, 4'd4, 64'h4647444500000000},
      {10'h00A, 8'h47, 1'b0, 4'd4, 64'h4746454400000000},
      {10'h009, 8'h13, 1'b0, 4'd2, 64'h1312000000000000},
      {10'h001, 8'h13, 1'b0, 4'd2, 64'h1312000000000000},
      {10'h008, 8'h9A, 1'b0, 4'd1, 64'h9A00000000000000},
      {10'h203, 8'h30, 1'b1, 4'd1, 64'h3000000000000000},
      {10'h203, 8'h31, 1'b0, 4'd8, 64'h3132333435363730}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_mode(input logic [MODE_W-1:0] m);
      mode_bits_i = m;
      mode_load_i = 1'b1;
      tick();
      mode_load_i = 1'b0;
   endtask

   task automatic issue(input logic [COL_W-1:0] c, input bit wr, input bit ap);
      cmd_col_i   = c;
      cmd_write_i = wr;
      cmd_ap_i    = ap;
      cmd_rw_i    = 1'b1;
      tick();
      cmd_rw_i    = 1'b0;
      cmd_write_i = 1'b0;
      cmd_ap_i    = 1'b0;
   endtask

   task automatic beat(input string req, input logic [COL_W-1:0] exp_col, input bit exp_done);
      chk(col_vld_o == 1'b1, req, 32'(col_vld_o), 32'd1);
      chk(col_o == exp_col, req, 32'(col_o), 32'(exp_col));
      chk(burst_done_o == exp_done, "R10", 32'(burst_done_o), 32'(exp_done));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R11 reset state
      chk(!col_vld_o && !burst_done_o && !cmd_reject_o && !mode_err_o, "R11",
          {28'd0, col_vld_o, burst_done_o, cmd_reject_o, mode_err_o}, 32'd0);
      rst_n = 1'b1;
      tick();
      // R11 default mode is a one-beat burst
      issue(8'h77, 1'b0, 1'b0);
      beat("R11", 8'h77, 1'b1);
      tick();
      chk(!col_vld_o, "R11", 32'(col_vld_o), 32'd0);

      // table walk: R1 R2 R3 R9
      for (int v = 0; v < NVEC; v++) begin
         logic [86:0] e;
         int          ln;
         string       tag;
         e  = VEC[v];
         ln = int'(e[67:64]);
         tag = e[86] ? "R9" : (e[80] ? "R3" : "R2");
         load_mode(e[86:77]);
         chk(!mode_err_o, "R8", 32'(mode_err_o), 32'd0);
         issue(e[76:69], e[68], 1'b0);
         for (int b = 0; b < ln; b++) begin
            beat(tag, e[63-8*b -: 8], b == ln - 1);
            if (b < ln - 1) tick();
         end
         tick();
         chk(!col_vld_o, "R1", 32'(col_vld_o), 32'd0);
      end

      // R4 full page wraps at the top of the row, then R6 precharge stops it
      load_mode(10'h007);
      issue(8'hFE, 1'b0, 1'b0);
      beat("R4", 8'hFE, 1'b0); tick();
      beat("R4", 8'hFF, 1'b0); tick();
      beat("R4", 8'h00, 1'b0); tick();
      beat("R4", 8'h01, 1'b0);
      pre_i = 1'b1;
      tick();
      pre_i = 1'b0;
      chk(!col_vld_o && !burst_done_o, "R6", {30'd0, col_vld_o, burst_done_o}, 32'd0);
      // R6 precharge while idle has no effect
      pre_i = 1'b1;
      tick();
      pre_i = 1'b0;
      chk(!col_vld_o && !cmd_reject_o, "R6", {30'd0, col_vld_o, cmd_reject_o}, 32'd0);

      // R5 restart mid-burst and back-to-back commands
      load_mode(10'h003);
      issue(8'h10, 1'b0, 1'b0);
      beat("R5", 8'h10, 1'b0); tick();
      beat("R5", 8'h11, 1'b0);
      issue(8'h55, 1'b1, 1'b0);
      beat("R5", 8'h55, 1'b0); tick();
      beat("R5", 8'h56, 1'b0); tick();
      beat("R5", 8'h57, 1'b0); tick();
      beat("R5", 8'h50, 1'b0);
      issue(8'h60, 1'b0, 1'b0);
      beat("R5", 8'h60, 1'b0);
      issue(8'h70, 1'b0, 1'b0);
      beat("R5", 8'h70, 1'b0);
      pre_i = 1'b1;
      tick();
      pre_i = 1'b0;
      chk(!col_vld_o, "R6", 32'(col_vld_o), 32'd0);

      // R7 auto precharge burst refuses both interrupt kinds
      load_mode(10'h002);
      issue(8'h80, 1'b0, 1'b1);
      beat("R7", 8'h80, 1'b0);
      issue(8'h90, 1'b0, 1'b0);
      beat("R7", 8'h81, 1'b0);
      chk(cmd_reject_o, "R7", 32'(cmd_reject_o), 32'd1);
      pre_i = 1'b1;
      tick();
      pre_i = 1'b0;
      beat("R7", 8'h82, 1'b0);
      chk(cmd_reject_o, "R7", 32'(cmd_reject_o), 32'd1);
      tick();
      beat("R7", 8'h83, 1'b1);
      chk(!cmd_reject_o, "R7", 32'(cmd_reject_o), 32'd0);
      tick();
      chk(!col_vld_o, "R7", 32'(col_vld_o), 32'd0);

      // R8 mode load during a burst is refused and the length is kept
      load_mode(10'h003);
      issue(8'hA0, 1'b0, 1'b0);
      beat("R8", 8'hA0, 1'b0);
      mode_bits_i = 10'h000;
      mode_load_i = 1'b1;
      tick();
      mode_load_i = 1'b0;
      chk(mode_err_o, "R8", 32'(mode_err_o), 32'd1);
      beat("R8", 8'hA1, 1'b0);
      for (int b = 2; b < 8; b++) tick();
      beat("R8", 8'hA7, 1'b1);
      tick();
      issue(8'hB4, 1'b0, 1'b0);
      beat("R8", 8'hB4, 1'b0); tick();
      beat("R8", 8'hB5, 1'b0);
      pre_i = 1'b1;
      tick();
      pre_i = 1'b0;

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule